// File: doc/BRIEF.md
# Sample Output Demultiplexer and Decimator

The block sits between the sampling core of a converter and its output pins. On every rising edge of the full-rate sample clock it takes one sample. It drives two data ports, A and B. Each port has a valid flag. It also produces a derived data clock, `dclk_o`.

Three static select inputs set the operation:

- `rate_sel_i` chooses full rate or a reduced rate.
- `dec_sel_i` chooses, at reduced rate, between keeping one sample in two and keeping one in `DEC_N` (default 5).
- `dup_i` makes port B copy port A. Without it, port B is either idle or, at half rate, carries the older sample of each pair.

A phase counter marks frames of 1, 2 or `DEC_N` samples. The selects are read only at the start of a frame. Data ports change only on the clock edge on which `dclk_o` rises. The data therefore stays stable for a full `dclk_o` period.

Top module: `adc_out_demux`

## Requirements
- R1: With `rate_sel_i`=0 (full rate), `dec_sel_i` has no effect. After every clock edge, port A holds the sample taken on that edge. With `dup_i`=0, port B is inactive.
- R2: At full rate with `dup_i`=1, port B carries the same value as port A, and both valid flags are high.
- R3: With `rate_sel_i`=1, `dec_sel_i`=0 and `dup_i`=0, samples form pairs from the first edge after reset. On the second edge of each pair, port B takes the first sample of the pair and port A takes the second. Both valid flags are high.
- R4: With `rate_sel_i`=1, `dec_sel_i`=0 and `dup_i`=1, both ports take the second sample of each pair, and the first sample is dropped.
- R5: With `rate_sel_i`=1 and `dec_sel_i`=1, the ports update on edges 0, 5, 10, ... after reset, with the sample of that edge. The other four samples are dropped. Port B is inactive when `dup_i`=0 and equals port A when `dup_i`=1.
- R6: An inactive port drives all-zero data with its valid flag low. Before the first update after reset, both ports are in this state.
- R7: Between update edges, both ports hold their values.
- R8: At half rate, `dclk_o` is high for the one clock period after each update edge and low for the next. In decimation mode, `dclk_o` is high for 2.5 clock periods from the update edge and low for 2.5 periods.
- R9: At full rate, `dclk_o` follows `clk_i` from the first falling clock edge after the first update.
- R10: While `rst_ni` is low, both ports are zero with valid flags low, and `dclk_o` is low.
- R11: A change of the select inputs takes effect only on the first edge of a new frame. A pair or decimation frame already in progress completes under the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DW | Sample taken on each rising edge |
| rate_sel_i | input | 1 | 0: full rate, 1: reduced rate |
| dec_sel_i | input | 1 | At reduced rate: 0 keeps one of 2, 1 keeps one of DEC_N |
| dup_i | input | 1 | Port B copies port A |
| a_data_o | output | DW | Port A data |
| a_vld_o | output | 1 | Port A active |
| b_data_o | output | DW | Port B data |
| b_vld_o | output | 1 | Port B active |
| dclk_o | output | 1 | Derived data clock |

## Verification
The checker's data-relation properties assume that the select inputs are quasi-static. These properties fire only after the selects have been unchanged for at least two full decimation frames, which covers the frame-boundary lag of R11. Samples are assumed to change only away from the rising edge.

The stimulus applies one setting per reset for most runs. It drives samples at three quarters of the period. In the two mid-frame switch runs, the selects change at that same point, inside a frame.

// File: rtl/adc_out_pkg.sv
package adc_out_pkg;
  typedef enum logic [1:0] {
    RATE_FULL = 2'd0,
    RATE_HALF = 2'd1,
    RATE_DEC  = 2'd2
  } rate_e;

  typedef struct packed {
    rate_e rate;
    logic  dup;
  } cfg_t;
endpackage

// File: rtl/adc_out_phase.sv
module adc_out_phase
  import adc_out_pkg::*;
#(
  parameter int DEC_N = 5,
  localparam int CW = (DEC_N > 2) ? $clog2(DEC_N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rate_sel_i,
  input  logic          dec_sel_i,
  input  logic          dup_i,
  output cfg_t          cfg_o,
  output cfg_t          cfg_q_o,
  output logic [CW-1:0] cnt_o,
  output logic          upd_o
);
  logic [CW-1:0] cnt_q;
  cfg_t          cfg_q, live, eff;
  logic          last;

  always_comb begin
    live.dup  = dup_i;
    if (!rate_sel_i)    live.rate = RATE_FULL;
    else if (dec_sel_i) live.rate = RATE_DEC;
    else                live.rate = RATE_HALF;
  end

  // selects are only honoured at frame start
  assign eff = (cnt_q == '0) ? live : cfg_q;

  always_comb begin
    unique case (eff.rate)
      RATE_HALF: begin
        last  = (cnt_q == CW'(1));
        upd_o = (cnt_q == CW'(1));
      end
      RATE_DEC: begin
        last  = (cnt_q == CW'(DEC_N - 1));
        upd_o = (cnt_q == '0);
      end
      default: begin
        last  = 1'b1;
        upd_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cfg_q <= '{rate: RATE_HALF, dup: 1'b0};
    end else begin
      cnt_q <= last ? '0 : cnt_q + CW'(1);
      cfg_q <= eff;
    end
  end

  assign cfg_o   = eff;
  assign cfg_q_o = cfg_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/adc_out_path.sv
module adc_out_path
  import adc_out_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEC_N = 5,
  localparam int CW = (DEC_N > 2) ? $clog2(DEC_N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          upd_i,
  input  logic [DW-1:0] sample_i,
  output logic [DW-1:0] a_data_o,
  output logic          a_vld_o,
  output logic [DW-1:0] b_data_o,
  output logic          b_vld_o
);
  logic [DW-1:0] pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pair_q <= '0;
    else if (cfg_i.rate == RATE_HALF && cnt_i == '0) pair_q <= sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_data_o <= '0;
      a_vld_o  <= 1'b0;
      b_data_o <= '0;
      b_vld_o  <= 1'b0;
    end else if (upd_i) begin
      a_data_o <= sample_i;
      a_vld_o  <= 1'b1;
      if (cfg_i.rate == RATE_HALF) begin
        b_data_o <= cfg_i.dup ? sample_i : pair_q;
        b_vld_o  <= 1'b1;
      end else begin
        b_data_o <= cfg_i.dup ? sample_i : '0;
        b_vld_o  <= cfg_i.dup;
      end
    end
  end
endmodule

// File: rtl/adc_out_clkgen.sv
module adc_out_clkgen
  import adc_out_pkg::*;
#(
  parameter int DEC_N = 5,
  localparam int CW = (DEC_N > 2) ? $clog2(DEC_N) : 1,
  localparam int HI_EDGES = DEC_N / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  cfg_t          cfg_q_i,
  input  logic [CW-1:0] cnt_i,
  output logic          dclk_o
);
  logic d2_q, p_q, n_w, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d2_q <= 1'b0;
      p_q  <= 1'b0;
    end else begin
      d2_q <= (cfg_i.rate == RATE_HALF) && (cnt_i == CW'(1));
      p_q  <= (cfg_i.rate == RATE_DEC) && (cnt_i < CW'(HI_EDGES));
    end
  end

  generate
    if (DEC_N % 2 == 1) begin : g_odd
      logic n_q;
      // half-period extension for odd division
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) n_q <= 1'b0;
        else         n_q <= p_q;
      end
      assign n_w = n_q;
    end else begin : g_even
      assign n_w = 1'b0;
    end
  endgenerate

  // mux select moves only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= (cfg_q_i.rate == RATE_FULL);
  end

  assign dclk_o = sel_q ? clk_i : (d2_q | p_q | n_w);
endmodule

// File: rtl/adc_out_demux.sv
module adc_out_demux
  import adc_out_pkg::*;
#(
  parameter int DW = 8,
  parameter int DEC_N = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sample_i,
  input  logic          rate_sel_i,
  input  logic          dec_sel_i,
  input  logic          dup_i,
  output logic [DW-1:0] a_data_o,
  output logic          a_vld_o,
  output logic [DW-1:0] b_data_o,
  output logic          b_vld_o,
  output logic          dclk_o
);
  localparam int CW = (DEC_N > 2) ? $clog2(DEC_N) : 1;

  cfg_t          cfg, cfg_q;
  logic [CW-1:0] cnt;
  logic          upd;

  adc_out_phase #(.DEC_N(DEC_N)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rate_sel_i(rate_sel_i), .dec_sel_i(dec_sel_i), .dup_i(dup_i),
    .cfg_o(cfg), .cfg_q_o(cfg_q), .cnt_o(cnt), .upd_o(upd)
  );

  adc_out_path #(.DW(DW), .DEC_N(DEC_N)) u_path (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg), .cnt_i(cnt), .upd_i(upd),
    .sample_i(sample_i),
    .a_data_o(a_data_o), .a_vld_o(a_vld_o),
    .b_data_o(b_data_o), .b_vld_o(b_vld_o)
  );

  adc_out_clkgen #(.DEC_N(DEC_N)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg), .cfg_q_i(cfg_q),
    .cnt_i(cnt), .dclk_o(dclk_o)
  );
endmodule

// File: rtl/adc_out_demux_chk.sv
module adc_out_demux_chk #(
  parameter int DW = 8,
  parameter int DEC_N = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] sample_i,
  input logic          rate_sel_i,
  input logic          dec_sel_i,
  input logic          dup_i,
  input logic [DW-1:0] a_data_o,
  input logic          a_vld_o,
  input logic [DW-1:0] b_data_o,
  input logic          b_vld_o
);
  localparam int SETTLE = 2 * DEC_N + 2;
  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] stab_q;
  logic [2:0]    sel_q;
  logic          settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stab_q <= '0;
      sel_q  <= '0;
    end else begin
      sel_q <= {rate_sel_i, dec_sel_i, dup_i};
      if (sel_q != {rate_sel_i, dec_sel_i, dup_i}) stab_q <= '0;
      else if (stab_q != SW'(SETTLE))              stab_q <= stab_q + SW'(1);
    end
  end

  assign settled = (stab_q == SW'(SETTLE));

  AST_A_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_vld_o |-> a_data_o == '0); // R6
  AST_B_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_vld_o |-> b_data_o == '0); // R6
  AST_DUP_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && dup_i && b_vld_o) |-> b_data_o == a_data_o); // R2
  AST_ONE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && !dup_i && (!rate_sel_i || dec_sel_i)) |-> !b_vld_o); // R5
  AST_FULL_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && !rate_sel_i) |=> (a_vld_o && a_data_o == $past(sample_i))); // R1
endmodule

bind adc_out_demux adc_out_demux_chk #(.DW(DW), .DEC_N(DEC_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
  .rate_sel_i(rate_sel_i), .dec_sel_i(dec_sel_i), .dup_i(dup_i),
  .a_data_o(a_data_o), .a_vld_o(a_vld_o),
  .b_data_o(b_data_o), .b_vld_o(b_vld_o)
);

// File: tb/adc_out_demux_test.sv
module adc_out_demux_test;
  localparam int DW = 8;
  localparam int DEC_N = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          rate_sel_i = 1'b0, dec_sel_i = 1'b0, dup_i = 1'b0;
  logic [DW-1:0] a_data_o, b_data_o;
  logic          a_vld_o, b_vld_o, dclk_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic dclk_e, dclk_l;

  always #10 clk_i = ~clk_i;

  adc_out_demux #(.DW(DW), .DEC_N(DEC_N)) uut (.*);

  function automatic logic [DW-1:0] smp(input int k);
    return DW'((k * 37 + 11) % 256);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic rs, input logic ds, input logic dp);
    rst_ni = 1'b0;
    rate_sel_i = rs; dec_sel_i = ds; dup_i = dp;
    sample_i = smp(0);
    @(posedge clk_i); #5;
    chk("R10 a", {a_vld_o, a_data_o}, 0);
    chk("R10 b", {b_vld_o, b_data_o}, 0);
    chk("R10 dclk", dclk_o, 0);
    @(posedge clk_i); #5;
    rst_ni = 1'b1;
  endtask

  // one edge: early and late dclk samples, then drive next sample
  task automatic step(input int k);
    @(posedge clk_i); #5;
    dclk_e = dclk_o;
    #10;
    dclk_l = dclk_o;
    sample_i = smp(k + 1);
  endtask

  task automatic run_cfg(input logic rs, input logic ds, input logic dp, input int n);
    int u;
    logic av, bv, ee, el;
    logic [DW-1:0] ea, eb;
    string tg;
    do_reset(rs, ds, dp);
    for (int k = 0; k < n; k++) begin
      step(k);
      if (!rs) begin
        tg = dp ? "R2" : "R1";
        u = k; av = 1; bv = dp;
        ea = smp(u); eb = dp ? smp(u) : '0;
      end else if (!ds) begin
        tg = dp ? "R4" : "R3";
        u = (k % 2 == 1) ? k : k - 1;
        av = (u >= 1); bv = av;
        ea = av ? smp(u) : '0;
        eb = !av ? '0 : (dp ? smp(u) : smp(u - 1));
      end else begin
        tg = "R5";
        u = k - (k % DEC_N);
        av = 1; bv = dp;
        ea = smp(u); eb = dp ? smp(u) : '0;
      end
      if (k != u) tg = {tg, " R7"};
      if (!av || !bv) tg = {tg, " R6"};
      chk({tg, " a_vld"}, a_vld_o, av);
      chk({tg, " a_data"}, a_data_o, ea);
      chk({tg, " b_vld"}, b_vld_o, bv);
      chk({tg, " b_data"}, b_data_o, eb);
      if (!rs) begin
        ee = (k >= 1); el = 1'b0;
        if (k >= 1) begin
          chk("R9 dclk high", dclk_e, ee);
          chk("R9 dclk low", dclk_l, el);
        end
      end else if (!ds) begin
        ee = (k % 2 == 1); el = ee;
        chk("R8 dclk half early", dclk_e, ee);
        chk("R8 dclk half late", dclk_l, el);
      end else begin
        ee = (k % DEC_N) <= 2; el = (k % DEC_N) <= 1;
        chk("R8 dclk dec early", dclk_e, ee);
        chk("R8 dclk dec late", dclk_l, el);
      end
    end
  endtask

  initial begin
    // sweep all select combinations, including the ignored one at full rate
    for (int c = 0; c < 8; c++)
      run_cfg(c[2], c[1], c[0], 4 * DEC_N);

    // R11: decimation -> full rate requested mid-frame
    do_reset(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) step(k);
    rate_sel_i = 1'b0;
    step(8);
    chk("R11 dec hold e8", a_data_o, smp(5));
    step(9);
    chk("R11 dec hold e9", a_data_o, smp(5));
    step(10);
    chk("R11 new frame e10", a_data_o, smp(10));
    step(11);
    chk("R11 full rate e11", a_data_o, smp(11));
    chk("R9 dclk after switch", dclk_e, 1'b1);

    // R11: half-rate demux -> decimation requested inside a pair
    do_reset(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) step(k);
    dec_sel_i = 1'b1;
    step(3);
    chk("R11 pair completes a", a_data_o, smp(3));
    chk("R11 pair completes b", b_data_o, smp(2));
    chk("R11 pair b_vld", b_vld_o, 1'b1);
    step(4);
    chk("R11 dec frame a", a_data_o, smp(4));
    chk("R11 dec frame b_vld", b_vld_o, 1'b0);
    chk("R11 dec frame b zero", b_data_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule